// File: doc/BRIEF.md
# Shared PCM Level Meter

This block measures the signal level on one of four PCM channels. All four channels deliver a 16-bit two's-complement sample on a common bus, with one valid strobe per 8 kHz frame. A two-bit field in the control register picks the channel to measure. The block takes the magnitude of each sample of that channel, drops the lower bits, and adds the result into a saturating 15-bit accumulator. After a programmed number of frames, the sum is copied into a two-byte result, a ready flag is raised, and the accumulator starts over.

A host uses a byte-wide register port with a 2-bit address, a write strobe, a read strobe and separate data buses. Reading the upper result byte with the read strobe clears the ready flag. A result that has not been read is replaced by the next one without any notice. Together with test tones and loopbacks elsewhere on the line card, this lets software check a channel the way external PCM test equipment would.

Top module: `pcm_level_meter`

## Requirements
- R1: After reset, all four registers read 0x00, so the ready flag is 0.
- R2: Address 0 is the control byte: bit 0 is enable, bit 1 is metering mode, bits 3:2 are the channel select, and bits 7:4 read back as written. Address 1 holds the frame count. Both addresses read back what was last written.
- R3: Only the selected channel is measured. Channel k is carried on `samp_data[16k+15:16k]`.
- R4: Accumulation runs only while enable and metering mode are both 1. While either bit is 0, the accumulator stays clear, no result is produced, and the result registers keep their contents.
- R5: Each sample contributes min(|x|, 32767) shifted right by 7 bits, giving a value from 0 to 255.
- R6: Once the programmed number of valid frames has been accumulated (a count of 0 acts as 1), the sum is latched and ready is set. At address 2, bits 7:1 hold result[6:0] and bit 0 holds ready. At address 3, all eight bits hold result[14:7].
- R7: The accumulated sum saturates at 32767.
- R8: A strobed read of address 3 clears ready. A strobed read of address 2 leaves ready unchanged.
- R9: A new result overwrites an unread earlier one.
- R10: Writing the count register, or writing the control register with a different channel select, discards the partial sum and restarts the interval.
- R11: If a result is latched in the same cycle as a strobed read of address 3, ready ends up set and the new result is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | One-cycle strobe, once per frame |
| samp_data | input | 64 | Four 16-bit samples, channel k in bits 16k+15:16k |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, with side effect at address 3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |

## Verification
The checker enforces these rules on every cycle:
- The result only changes after a valid frame.
- Ready only rises on a frame.
- A strobed high-byte read with no frame present leaves ready low.
- A low-byte read keeps ready set.
- The accumulator is clear while metering is off.

The actual sums are checked only by the bench scenarios. These cover:
- the chosen lane
- rectification of negative values and of the most negative value
- saturation
- the zero count
- the restart after a count or channel change
- overwriting of an unread result
- a high-byte read that collides with a new latch

// File: rtl/pcm_level_meter.sv
module pcm_level_meter #(
  parameter int NCH   = 4,
  parameter int SW    = 16,
  parameter int CW    = 8,
  parameter int SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [NCH*SW-1:0] samp_data,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int RW  = 15;
  localparam int CHW = $clog2(NCH);

  logic [7:0]    ctrl_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] nsamp;
  logic [RW-1:0] acc;
  logic [RW-1:0] res;
  logic          ready;

  wire           en   = ctrl_q[0];
  wire           mode = ctrl_q[1];
  wire [CHW-1:0] chs  = ctrl_q[2 +: CHW];
  wire           run  = en & mode;

  logic [SW-1:0] lane [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = samp_data[g*SW +: SW];
  end

  wire [SW-1:0] sel    = lane[chs];
  wire [SW-1:0] negv   = -sel;
  wire [SW-1:0] absraw = sel[SW-1] ? negv : sel;
  wire [RW-1:0] mag15  = absraw[SW-1] ? {RW{1'b1}} : absraw[RW-1:0];
  wire [RW-1:0] magsh  = mag15 >> SHIFT;
  wire [RW:0]   sum    = {1'b0, acc} + {1'b0, magsh};
  wire [RW-1:0] sumsat = sum[RW] ? {RW{1'b1}} : sum[RW-1:0];

  wire [CW-1:0] lim_eff = (lim_q == '0) ? CW'(1) : lim_q;
  wire          last    = ({1'b0, nsamp} + (CW+1)'(1)) >= {1'b0, lim_eff};

  wire wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire wr_lim  = reg_wr && reg_addr == 2'd1;
  wire ch_chg  = wr_ctrl && (reg_wdata[2 +: CHW] != chs);
  wire restart = !run || wr_lim || ch_chg;
  wire latch   = !restart && samp_valid && last;
  wire hi_rd   = reg_rd && reg_addr == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_lim)  lim_q  <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      nsamp <= '0;
      res   <= '0;
    end else if (restart) begin
      acc   <= '0;
      nsamp <= '0;
    end else if (samp_valid) begin
      if (last) begin
        res   <= sumsat;
        acc   <= '0;
        nsamp <= '0;
      end else begin
        acc   <= sumsat;
        nsamp <= nsamp + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ready <= 1'b0;
    else if (latch) ready <= 1'b1;
    else if (hi_rd) ready <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = 8'(lim_q);
      2'd2:    reg_rdata = {res[6:0], ready};
      default: reg_rdata = res[14:7];
    endcase
  end
endmodule

// File: rtl/pcm_level_meter_chk.sv
module pcm_level_meter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        samp_valid,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic        run,
  input logic        ready,
  input logic [14:0] res,
  input logic [14:0] acc
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> $stable(res));
  p_ready_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(samp_valid));
  p_hi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3 && !samp_valid) |=> !ready);
  p_lo_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && ready) |=> ready);
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> acc == '0);
endmodule

bind pcm_level_meter pcm_level_meter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .run(run), .ready(ready), .res(res), .acc(acc)
);

// File: tb/pcm_level_meter_tb_top.sv
module pcm_level_meter_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        samp_valid = 0;
  logic [63:0] samp_data = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pcm_level_meter dut_i (.*);

  function automatic int mag(input logic [15:0] x);
    int v = int'($signed(x));
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v >> 7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic strobe_rd(input logic [1:0] a);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic frame(input logic [15:0] s0, s1, s2, s3);
    @(negedge clk); samp_data = {s3, s2, s1, s0}; samp_valid = 1;
    @(negedge clk); samp_valid = 0;
  endtask

  task automatic expect_res(input string req, input int r, input bit rdy);
    logic [7:0] lo, hi;
    peek(2'd2, lo); peek(2'd3, hi);
    chk(req, lo, ((r & 8'h7F) << 1) | rdy);
    chk(req, hi, (r >> 7) & 8'hFF);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d); chk("R1", d, 0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(0, 8'hAF); peek(0, d); chk("R2 ctrl", d, 8'hAF);
    wr(1, 8'd5);  peek(1, d); chk("R2 count", d, 5);
    wr(0, 8'h00);
  endtask

  task automatic t_basic;
    int e;
    wr(0, 8'h07); wr(1, 8'd3);
    frame(16'h7FFF, 16'd1000, 16'h8000, 16'h7FFF);
    frame(16'h7FFF, -16'sd2000, 16'h8000, 16'h7FFF);
    frame(16'h7FFF, 16'd300, 16'h8000, 16'h7FFF);
    e = mag(16'd1000) + mag(-16'sd2000) + mag(16'd300);
    expect_res("R3 R5 R6 lane1", e, 1);
  endtask

  task automatic t_zero_count;
    wr(1, 8'd0);
    frame(0, 16'h8000, 0, 0);
    expect_res("R6 count0 R5 minneg", 255, 1);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    strobe_rd(2); peek(2, d); chk("R8 lo keeps", d & 1, 1);
    strobe_rd(3); peek(2, d); chk("R8 hi clears", d & 1, 0);
  endtask

  task automatic t_overwrite;
    wr(1, 8'd1);
    frame(0, 16'd640, 0, 0);
    frame(0, 16'd1280, 0, 0);
    expect_res("R9 overwrite", 10, 1);
    strobe_rd(3);
  endtask

  task automatic t_disable;
    wr(0, 8'h05); frame(0, 16'd6400, 0, 0);
    expect_res("R4 mode0", 10, 0);
    wr(0, 8'h06); frame(0, 16'd6400, 0, 0);
    expect_res("R4 en0", 10, 0);
  endtask

  task automatic t_restart;
    wr(0, 8'h07); wr(1, 8'd4);
    frame(0, 16'd12800, 0, 0); frame(0, 16'd12800, 0, 0);
    wr(1, 8'd2);
    frame(0, 16'd256, 0, 0); frame(0, 16'd384, 0, 0);
    expect_res("R10 count write", 5, 1);
    strobe_rd(3);
    wr(1, 8'd3);
    frame(0, 16'd12800, 0, 0);
    wr(0, 8'h0B);
    for (int i = 0; i < 3; i++) frame(0, 16'd12800, -16'sd1024, 0);
    expect_res("R10 R3 ch change", 24, 1);
    strobe_rd(3);
  endtask

  task automatic t_sat;
    wr(0, 8'h07); wr(1, 8'd200);
    for (int i = 0; i < 200; i++) frame(0, 16'h8000, 0, 0);
    expect_res("R7 saturate", 32767, 1);
  endtask

  task automatic t_collide;
    wr(1, 8'd1);
    @(negedge clk);
    samp_data = {16'd0, 16'd0, 16'd0, 16'd0} | (64'd2560 << 16);
    samp_valid = 1; reg_addr = 3; reg_rd = 1;
    @(negedge clk); samp_valid = 0; reg_rd = 0;
    expect_res("R11 collide", 20, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_regs; t_basic; t_zero_count; t_clear; t_overwrite;
    t_disable; t_restart; t_sat; t_collide;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule